// File: doc/BRIEF.md
# Watermark Stop/Go Link Flow Controller

This block sits at the receiving end of a serial link that moves one phit per cycle. Arriving phits are written into a local FIFO and leave it toward the downstream logic in arrival order. The controller watches how full the FIFO is and sends control symbols back on a reverse channel. When the fill level climbs to a programmable upper mark it sends a stop symbol. After that, when the level drains down to a programmable lower mark, it sends a go symbol. Because of this hysteresis the reverse channel does not toggle on every phit.

Symbols can be lost on the reverse channel, so the receiver repeats its current status at a fixed interval even when nothing has changed. The block also holds the matching sender-side tracker. That tracker listens to symbols coming from the far end and keeps a transmit-enable flag. A stop clears the flag and a go sets it. Repeated symbols, idle symbols and the reserved code all leave the flag unchanged. The upper mark should sit below the FIFO depth by at least the round-trip delay in phits, so that phits already in flight after a stop still fit. A configuration in which the lower mark is not strictly below the upper mark raises an error flag.

Top module: `wm_flow_ctrl`

## Requirements
- R1: After reset, txEnable is 1, symOut is idle (2'b00), outValid is 0 and cfgError is 0.
- R2: Phits leave on outPhit in the order they were accepted. outValid is 1 exactly when the FIFO holds at least one phit, and a phit is consumed at a clock edge where outValid and outReady are both 1.
- R3: A phit offered while the FIFO already holds DEPTH phits is discarded. Occupancy never exceeds DEPTH, and the stored phits are unaffected.
- R4: In the go state, once occupancy is at or above hiMark, the next clock edge sends STOP (symOut = 2'b01) and enters the stopped state. The receiver stays stopped while occupancy is above loMark.
- R5: In the stopped state, once occupancy is at or below loMark, the next clock edge sends GO (symOut = 2'b10) and returns to the go state.
- R6: When no state change occurs, the current status (STOP if stopped, GO otherwise) is sent again RESEND_K cycles after the previous symbol. Every other cycle carries idle.
- R7: The sender tracker clears txEnable on the edge after symIn carries STOP (2'b01) and sets it on the edge after GO (2'b10). Idle (2'b00), reserved (2'b11) and repeated symbols leave it unchanged.
- R8: cfgError is 1 on the edge after loMark >= hiMark is presented, and 0 on the edge after loMark < hiMark is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A phit is present on inPhit |
| inPhit | input | DATA_W | Incoming phit from the link |
| outReady | input | 1 | Downstream takes the head phit |
| outValid | output | 1 | FIFO is not empty |
| outPhit | output | DATA_W | Head phit of the FIFO |
| hiMark | input | CNT_W | Upper occupancy mark (stop threshold) |
| loMark | input | CNT_W | Lower occupancy mark (go threshold) |
| symOut | output | 2 | Reverse symbol to the upstream sender |
| symIn | input | 2 | Reverse symbol from the far-end receiver |
| txEnable | output | 1 | Sender may transmit |
| cfgError | output | 1 | Marks are not ordered low < high |

## Verification
The FIFO occupancy is registered, so STOP or GO appears on symOut one edge after the edge that brought the occupancy to its mark. That is the second edge after the phit that crosses the mark is offered. txEnable and cfgError follow their inputs after one edge. A repeated status follows its previous symbol after exactly RESEND_K edges. The bench applies every input just after a falling edge and reads the outputs at the next falling edge. It places each symbol check at the exact falling edge worked out above, and it also checks one edge earlier that the symbol has not yet appeared. The scoreboard compares outPhit against the queue head before the edge that consumes it.

// File: rtl/wm_flow_pkg.sv
package wm_flow_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_STOP = 2'b01,
    SYM_GO   = 2'b10,
    SYM_RSVD = 2'b11
  } linkSym_e;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/wm_fifo_dp.sv
module wm_fifo_dp
  import wm_flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic [DATA_W-1:0] inPhit,
  output logic [DATA_W-1:0] outPhit,
  output logic [CNT_W-1:0]  occ
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= inPhit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign outPhit = store[rdPtr];
endmodule

// File: rtl/wm_rx_ctrl.sv
module wm_rx_ctrl
  import wm_flow_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int RESEND_K = 8,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [CNT_W-1:0] occ,
  input  logic [CNT_W-1:0] hiMark,
  input  logic [CNT_W-1:0] loMark,
  output fifoStrobe_t      strb,
  output logic             outValid,
  output logic [1:0]       symOut,
  output logic             rxHalt,
  output logic             cfgError
);
  localparam int TMR_W = (RESEND_K > 2) ? $clog2(RESEND_K) : 1;

  logic [TMR_W-1:0] tmr;
  logic             hitHigh, hitLow, resendDue;
  logic             isFull, isEmpty;

  assign isFull   = (occ == CNT_W'(DEPTH));
  assign isEmpty  = (occ == '0);
  assign strb.push = inValid && !isFull;
  assign strb.pop  = outReady && !isEmpty;
  assign outValid  = !isEmpty;

  assign hitHigh   = !rxHalt && (occ >= hiMark);
  assign hitLow    = rxHalt && (occ <= loMark);
  assign resendDue = (tmr == TMR_W'(RESEND_K - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHalt <= 1'b0;
      symOut <= SYM_NONE;
      tmr    <= '0;
    end else if (hitHigh) begin
      rxHalt <= 1'b1;
      symOut <= SYM_STOP;
      tmr    <= '0;
    end else if (hitLow) begin
      rxHalt <= 1'b0;
      symOut <= SYM_GO;
      tmr    <= '0;
    end else if (resendDue) begin
      symOut <= rxHalt ? SYM_STOP : SYM_GO;
      tmr    <= '0;
    end else begin
      symOut <= SYM_NONE;
      tmr    <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgError <= 1'b0;
    else       cfgError <= (loMark >= hiMark);
  end
endmodule

// File: rtl/wm_tx_gate.sv
module wm_tx_gate
  import wm_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] symIn,
  output logic       txEnable
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnable <= 1'b1;
    end else begin
      case (linkSym_e'(symIn))
        SYM_STOP: txEnable <= 1'b0;
        SYM_GO:   txEnable <= 1'b1;
        default:  txEnable <= txEnable;
      endcase
    end
  end
endmodule

// File: rtl/wm_flow_ctrl.sv
module wm_flow_ctrl
  import wm_flow_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int RESEND_K = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inPhit,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outPhit,
  input  logic [CNT_W-1:0]  hiMark,
  input  logic [CNT_W-1:0]  loMark,
  output logic [1:0]        symOut,
  input  logic [1:0]        symIn,
  output logic              txEnable,
  output logic              cfgError
);
  fifoStrobe_t      strb;
  logic [CNT_W-1:0] occ;
  logic             rxHalt;

  wm_rx_ctrl #(.DEPTH(DEPTH), .RESEND_K(RESEND_K), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .occ(occ), .hiMark(hiMark), .loMark(loMark), .strb(strb),
    .outValid(outValid), .symOut(symOut), .rxHalt(rxHalt), .cfgError(cfgError)
  );

  wm_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inPhit(inPhit),
    .outPhit(outPhit), .occ(occ)
  );

  wm_tx_gate u_tx (
    .clk(clk), .rstN(rstN), .symIn(symIn), .txEnable(txEnable)
  );
endmodule

// File: rtl/wm_flow_ctrl_chk.sv
module wm_flow_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             outReady,
  input logic [CNT_W-1:0] occ,
  input logic [CNT_W-1:0] hiMark,
  input logic [CNT_W-1:0] loMark,
  input logic             rxHalt,
  input logic [1:0]       symOut,
  input logic [1:0]       symIn,
  input logic             txEnable,
  input logic             cfgError
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH) && !outReady) |=> occ == CNT_W'(DEPTH));
  p_stop_on_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!rxHalt && occ >= hiMark) |=> (symOut == 2'b01 && rxHalt));
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxHalt && occ > loMark) |=> rxHalt);
  p_go_on_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxHalt && occ <= loMark) |=> (symOut == 2'b10 && !rxHalt));
  p_stop_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    (symOut == 2'b01) |-> rxHalt);
  p_go_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    (symOut == 2'b10) |-> !rxHalt);
  p_tx_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (symIn == 2'b01) |=> !txEnable);
  p_tx_go_r7: assert property (@(posedge clk) disable iff (!rstN)
    (symIn == 2'b10) |=> txEnable);
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (symIn == 2'b00 || symIn == 2'b11) |=> $stable(txEnable));
  p_cfg_bad_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loMark >= hiMark) |=> cfgError);
  p_cfg_good_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loMark < hiMark) |=> !cfgError);
endmodule

bind wm_flow_ctrl wm_flow_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .outReady(outReady), .occ(occ),
  .hiMark(hiMark), .loMark(loMark), .rxHalt(rxHalt), .symOut(symOut),
  .symIn(symIn), .txEnable(txEnable), .cfgError(cfgError)
);

// File: tb/wm_flow_ctrl_bench.sv
`timescale 1ns/1ps
module wm_flow_ctrl_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int K      = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inPhit = '0;
  logic              outReady = 1'b0;
  logic              outValid;
  logic [DATA_W-1:0] outPhit;
  logic [CNT_W-1:0]  hiMark = CNT_W'(12);
  logic [CNT_W-1:0]  loMark = CNT_W'(4);
  logic [1:0]        symOut;
  logic [1:0]        symIn = 2'b00;
  logic              txEnable;
  logic              cfgError;

  int errors = 0;
  int total  = 0;
  int mOcc   = 0;
  int popped = 0;
  bit done   = 0;
  logic [DATA_W-1:0] expQ[$];

  always #5 clk = ~clk;

  wm_flow_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RESEND_K(K)) u_wm_flow_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPhit(inPhit),
    .outReady(outReady), .outValid(outValid), .outPhit(outPhit),
    .hiMark(hiMark), .loMark(loMark), .symOut(symOut), .symIn(symIn),
    .txEnable(txEnable), .cfgError(cfgError)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver and scoreboard monitor: called just after a falling edge.
  task automatic tick(input logic v, input logic [DATA_W-1:0] d, input logic r);
    inValid  = v;
    inPhit   = d;
    outReady = r;
    chk(outValid == (mOcc > 0), "R2 outValid", int'(outValid), int'(mOcc > 0));
    if (r && mOcc > 0) begin
      chk(outPhit == expQ[0], "R2 order", int'(outPhit), int'(expQ[0]));
      void'(expQ.pop_front());
      mOcc--;
      popped++;
    end
    if (v && (mOcc + ((r && expQ.size() < mOcc) ? 1 : 0)) < DEPTH) begin
      expQ.push_back(d);
      mOcc++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int cnt;
    bit sawGo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txEnable == 1'b1, "R1 txEnable", int'(txEnable), 1);
    chk(symOut == 2'b00, "R1 symOut", int'(symOut), 0);
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(cfgError == 1'b0, "R1 cfgError", int'(cfgError), 0);

    // R8 configuration check
    loMark = CNT_W'(12);
    idle(1);
    chk(cfgError == 1'b1, "R8 lo==hi", int'(cfgError), 1);
    loMark = CNT_W'(13);
    idle(1);
    chk(cfgError == 1'b1, "R8 lo>hi", int'(cfgError), 1);
    loMark = CNT_W'(4);
    idle(1);
    chk(cfgError == 1'b0, "R8 lo<hi", int'(cfgError), 0);

    // R4 stop at high mark (hi=12)
    for (int i = 0; i < 12; i++) tick(1'b1, DATA_W'(8'h10 + i), 1'b0);
    chk(symOut != 2'b01, "R4 not early", int'(symOut), 0);
    idle(1);
    chk(symOut == 2'b01, "R4 stop", int'(symOut), 1);

    // R6 resend of STOP after K cycles
    cnt = 0;
    for (int i = 0; i < 2 * K; i++) begin
      idle(1);
      cnt++;
      if (symOut != 2'b00) break;
    end
    chk(cnt == K, "R6 stop resend gap", cnt, K);
    chk(symOut == 2'b01, "R6 stop resend value", int'(symOut), 1);

    // R5 go at low mark (lo=4): 8 pops take 12 -> 4
    sawGo = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, '0, 1'b1);
      if (symOut == 2'b10) sawGo = 1;
    end
    chk(!sawGo, "R4 held until low mark", int'(sawGo), 0);
    idle(1);
    chk(symOut == 2'b10, "R5 go", int'(symOut), 2);

    // R6 resend of GO after K cycles
    cnt = 0;
    for (int i = 0; i < 2 * K; i++) begin
      idle(1);
      cnt++;
      if (symOut != 2'b00) break;
    end
    chk(cnt == K, "R6 go resend gap", cnt, K);
    chk(symOut == 2'b10, "R6 go resend value", int'(symOut), 2);

    for (int i = 0; i < 4; i++) tick(1'b0, '0, 1'b1);
    chk(outValid == 1'b0, "R2 drained", int'(outValid), 0);

    // R3 overflow: hi=16 so the FIFO can fill completely
    hiMark = CNT_W'(16);
    loMark = CNT_W'(2);
    popped = 0;
    for (int i = 0; i < 20; i++) tick(1'b1, DATA_W'(8'h40 + i), 1'b0);
    for (int i = 0; i < 20; i++) tick(1'b0, '0, 1'b1);
    chk(popped == 16, "R3 kept phits", popped, 16);
    chk(outValid == 1'b0, "R3 empty after drain", int'(outValid), 0);

    // R2 mixed push/pop pattern
    hiMark = CNT_W'(12);
    loMark = CNT_W'(4);
    for (int i = 0; i < 60; i++)
      tick(logic'((i % 3) != 0), DATA_W'(8'h80 + i), logic'((i % 4) != 1));
    for (int i = 0; i < 40; i++) tick(1'b0, '0, 1'b1);
    chk(outValid == 1'b0 && expQ.size() == 0, "R2 mixed drained",
        int'(outValid), 0);

    // R7 sender tracker
    symIn = 2'b01; idle(1);
    chk(txEnable == 1'b0, "R7 stop", int'(txEnable), 0);
    symIn = 2'b01; idle(1);
    chk(txEnable == 1'b0, "R7 dup stop", int'(txEnable), 0);
    symIn = 2'b00; idle(1);
    chk(txEnable == 1'b0, "R7 idle keeps", int'(txEnable), 0);
    symIn = 2'b11; idle(1);
    chk(txEnable == 1'b0, "R7 reserved keeps", int'(txEnable), 0);
    symIn = 2'b10; idle(1);
    chk(txEnable == 1'b1, "R7 go", int'(txEnable), 1);
    symIn = 2'b10; idle(1);
    chk(txEnable == 1'b1, "R7 dup go", int'(txEnable), 1);
    symIn = 2'b11; idle(1);
    chk(txEnable == 1'b1, "R7 reserved keeps go", int'(txEnable), 1);
    symIn = 2'b00; idle(2);

    done = 1;
    finish_run();
  end
endmodule